// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block holds one address reservation for each of a small number of hardware threads that share a memory. Each thread presents at most one request per cycle. A request is a load-reserved, a store-conditional, a plain store or a no-op, and carries an address. The block answers every request one cycle later. For a store-conditional the answer says whether the store may go ahead. Addresses are compared per 8-byte granule.

A separate snoop input stands in for an invalidation arriving from the coherence fabric. A snoop that hits a reservation made in the last few cycles is held back rather than applied at once. This gives the owning thread a bounded window in which to finish its store-conditional, so threads that keep stealing one another's reservations still make progress. A held-back snoop is applied when the window closes. Requests that arrive together are resolved in thread-index order, and the snoop is applied after all of them.

Top module: `resv_monitor`

## Requirements
- R1: After reset no thread holds a reservation, and `resp_valid` and `resp_ok` are all zero.
- R2: Operation codes per thread are 2'b01 load-reserved, 2'b10 store-conditional, 2'b11 plain store and 2'b00 no-op. Every valid request gets `resp_valid` high in the following cycle. A load-reserved stores its address granule (address bits above bit 2) in the issuing thread's entry and answers with `resp_ok` low.
- R3: A load-reserved removes any reservation another thread holds on the same granule.
- R4: A store-conditional answers `resp_ok` high only if the issuing thread holds a live reservation on the same granule. Address bits 2:0 are ignored. Otherwise it answers low.
- R5: A store-conditional removes the issuing thread's reservation whether it succeeds or fails.
- R6: A successful store-conditional, or any plain store, removes other threads' reservations on that granule. A failed store-conditional removes none.
- R7: A snoop on a reserved granule whose deferral window has closed removes that reservation in the same cycle.
- R8: A load-reserved opens a window of WIN cycles. A snoop that hits in the first WIN-1 cycles is deferred, with at most one pending per thread. It is applied at the cycle the window ends, so a store-conditional arriving before that cycle still succeeds and one arriving at that cycle fails.
- R9: Requests in the same cycle are applied in order of thread index, lowest first, and each request sees the effects of the lower-indexed ones. The snoop is applied after all requests.
- R10: A no-op request, or an idle thread, changes no reservation. A no-op is still answered, with `resp_ok` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NT | Request present, one bit per thread |
| req_op | input | 2*NT | Operation code, two bits per thread |
| req_addr | input | NT*AW | Byte address, AW bits per thread |
| snoop_valid | input | 1 | Invalidation present |
| snoop_addr | input | AW | Invalidation byte address |
| resp_valid | output | NT | Answer to last cycle's request |
| resp_ok | output | NT | Store-conditional success |

## Verification
A wrong reservation entry or a wrong counter is invisible until a later store-conditional from that thread. It shows up as a wrong `resp_ok` one cycle after that request. A counter that is off by one moves the cycle at which a deferred snoop takes effect. For that reason the bench places store-conditionals exactly on both sides of the window edge, and it runs random traffic on only four granules so that the tracked state is exercised on nearly every cycle.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int NT  = 4,
  parameter int AW  = 32,
  parameter int GB  = 3,
  parameter int WIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NT-1:0]   req_valid,
  input  logic [2*NT-1:0] req_op,
  input  logic [NT*AW-1:0] req_addr,
  input  logic            snoop_valid,
  input  logic [AW-1:0]   snoop_addr,
  output logic [NT-1:0]   resp_valid,
  output logic [NT-1:0]   resp_ok
);
  localparam int GW = AW - GB;
  localparam int CW = (WIN < 1) ? 1 : $clog2(WIN + 1);
  localparam logic [1:0] OP_LR = 2'b01, OP_SC = 2'b10, OP_ST = 2'b11;

  logic [NT-1:0] rv, rv_n, pend, pend_n, ok_n;
  logic [GW-1:0] ra [NT];
  logic [GW-1:0] ra_n [NT];
  logic [CW-1:0] cnt [NT];
  logic [CW-1:0] cnt_n [NT];
  logic [GW-1:0] sg;

  assign sg = snoop_addr[AW-1:GB];

  always_comb begin
    logic [GW-1:0] g;
    logic hit;
    g = '0;
    hit = 1'b0;
    rv_n = rv;
    pend_n = pend;
    ok_n = '0;
    for (int i = 0; i < NT; i++) begin
      ra_n[i] = ra[i];
      cnt_n[i] = (cnt[i] != '0) ? cnt[i] - 1'b1 : '0;
      if (cnt[i] == CW'(1) && pend[i]) begin
        rv_n[i] = 1'b0;
        pend_n[i] = 1'b0;
      end
    end
    for (int i = 0; i < NT; i++) begin
      if (req_valid[i]) begin
        g = req_addr[i*AW+GB +: GW];
        hit = rv_n[i] && (ra_n[i] == g);
        case (req_op[2*i +: 2])
          OP_LR: begin
            for (int j = 0; j < NT; j++)
              if (j != i && rv_n[j] && ra_n[j] == g) begin
                rv_n[j] = 1'b0;
                pend_n[j] = 1'b0;
              end
            rv_n[i] = 1'b1;
            ra_n[i] = g;
            cnt_n[i] = CW'(WIN);
            pend_n[i] = 1'b0;
          end
          OP_SC: begin
            ok_n[i] = hit;
            rv_n[i] = 1'b0;
            pend_n[i] = 1'b0;
            if (hit)
              for (int j = 0; j < NT; j++)
                if (j != i && rv_n[j] && ra_n[j] == g) begin
                  rv_n[j] = 1'b0;
                  pend_n[j] = 1'b0;
                end
          end
          OP_ST: begin
            for (int j = 0; j < NT; j++)
              if (j != i && rv_n[j] && ra_n[j] == g) begin
                rv_n[j] = 1'b0;
                pend_n[j] = 1'b0;
              end
          end
          default: ;
        endcase
      end
    end
    if (snoop_valid)
      for (int i = 0; i < NT; i++)
        if (rv_n[i] && ra_n[i] == sg) begin
          if (cnt_n[i] != '0) pend_n[i] = 1'b1;
          else rv_n[i] = 1'b0;
        end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv <= '0;
      pend <= '0;
      resp_valid <= '0;
      resp_ok <= '0;
      for (int i = 0; i < NT; i++) begin
        ra[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      rv <= rv_n;
      pend <= pend_n;
      resp_valid <= req_valid;
      resp_ok <= ok_n;
      for (int i = 0; i < NT; i++) begin
        ra[i] <= ra_n[i];
        cnt[i] <= cnt_n[i];
      end
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_chk
    assert_ok_from_sc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_ok[t] |-> $past(req_valid[t] && req_op[2*t +: 2] == OP_SC));
    assert_ok_had_resv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_ok[t] |-> $past(rv[t] && ra[t] == req_addr[t*AW+GB +: GW]));
    assert_sc_consumes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid[t] && $past(req_op[2*t +: 2] == OP_SC)) |-> !rv[t]);
    assert_lr_opens_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid[t] && req_op[2*t +: 2] == OP_LR) |-> cnt[t] == CW'(WIN));
    assert_pend_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend[t] |-> cnt[t] != '0);
    assert_snoop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(snoop_valid && !req_valid[t] && rv[t] && cnt[t] == '0 && ra[t] == sg) |-> !rv[t]);
  end
endmodule

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;
  localparam int NT = 4, AW = 32, WIN = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NT-1:0] v;
  logic [1:0] op [NT];
  logic [AW-1:0] ad [NT];
  logic snp_v;
  logic [AW-1:0] snp_a;
  logic [2*NT-1:0] op_bus;
  logic [NT*AW-1:0] ad_bus;
  logic [NT-1:0] resp_valid, resp_ok;

  always_comb
    for (int t = 0; t < NT; t++) begin
      op_bus[2*t +: 2] = op[t];
      ad_bus[t*AW +: AW] = ad[t];
    end

  resv_monitor #(.NT(NT), .AW(AW), .GB(3), .WIN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_op(op_bus), .req_addr(ad_bus),
    .snoop_valid(snp_v), .snoop_addr(snp_a), .resp_valid(resp_valid), .resp_ok(resp_ok));

  int total = 0, bad = 0;
  bit done = 0;
  bit mv [NT];
  bit mp [NT];
  logic [AW-4:0] ma [NT];
  int mc [NT];
  bit evl [NT];
  bit eok [NT];

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string tagof(input int t);
    if (!v[t]) return "R10";
    case (op[t])
      2'b01: return "R2";
      2'b10: return "R4";
      2'b11: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic drop_others(input int me, input logic [AW-4:0] g);
    for (int k = 0; k < NT; k++)
      if (k != me && mv[k] && ma[k] == g) begin mv[k] = 0; mp[k] = 0; end
  endtask

  task automatic model();
    for (int t = 0; t < NT; t++)
      if (mc[t] > 0) begin
        if (mc[t] == 1 && mp[t]) begin mv[t] = 0; mp[t] = 0; end
        mc[t]--;
      end
    for (int t = 0; t < NT; t++) begin
      evl[t] = v[t];
      eok[t] = 0;
      if (v[t]) begin
        logic [AW-4:0] g;
        g = ad[t][AW-1:3];
        if (op[t] == 2'b01) begin
          drop_others(t, g);
          mv[t] = 1; ma[t] = g; mc[t] = WIN; mp[t] = 0;
        end else if (op[t] == 2'b10) begin
          eok[t] = mv[t] && ma[t] == g;
          mv[t] = 0; mp[t] = 0;
          if (eok[t]) drop_others(t, g);
        end else if (op[t] == 2'b11) drop_others(t, g);
      end
    end
    if (snp_v)
      for (int t = 0; t < NT; t++)
        if (mv[t] && ma[t] == snp_a[AW-1:3]) begin
          if (mc[t] > 0) mp[t] = 1;
          else mv[t] = 0;
        end
  endtask

  task automatic cyc();
    model();
    @(posedge clk); #2;
    for (int t = 0; t < NT; t++) chk(tagof(t), {resp_valid[t], resp_ok[t]}, {evl[t], eok[t]});
    @(negedge clk);
    v = '0; snp_v = 0;
    for (int t = 0; t < NT; t++) begin op[t] = 2'b00; ad[t] = '0; end
  endtask

  task automatic rq(input int t, input logic [1:0] o, input logic [AW-1:0] a);
    v[t] = 1; op[t] = o; ad[t] = a;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [AW-1:0] A = 32'h100, B = 32'h208, C = 32'h340, D = 32'h4a0;

  initial begin
    v = '0; snp_v = 0; snp_a = '0;
    for (int t = 0; t < NT; t++) begin
      op[t] = 2'b00; ad[t] = '0; mv[t] = 0; mp[t] = 0; ma[t] = '0; mc[t] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1", {|resp_valid, |resp_ok}, 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {|resp_valid, |resp_ok}, 2'b00);

    rq(0, 2'b01, A); cyc();
    idle(WIN + 1);
    rq(0, 2'b10, A + 5); cyc(); chk("R4", {1'b1, resp_ok[0]}, 2'b11);
    rq(0, 2'b10, A); cyc(); chk("R5", {1'b1, resp_ok[0]}, 2'b10);

    rq(0, 2'b01, A); cyc();
    rq(1, 2'b01, A); cyc();
    rq(0, 2'b10, A); rq(2, 2'b10, B); cyc(); chk("R3", {1'b1, resp_ok[0]}, 2'b10);
    rq(1, 2'b10, A); cyc(); chk("R3", {1'b1, resp_ok[1]}, 2'b11);

    rq(0, 2'b01, B); cyc();
    rq(1, 2'b11, B + 3); cyc();
    rq(0, 2'b10, B); cyc(); chk("R6", {1'b1, resp_ok[0]}, 2'b10);
    rq(0, 2'b01, B); cyc();
    rq(1, 2'b10, B); cyc(); chk("R6", {1'b1, resp_ok[1]}, 2'b10);
    rq(0, 2'b10, B); cyc(); chk("R6", {1'b1, resp_ok[0]}, 2'b11);

    rq(0, 2'b01, A); rq(1, 2'b01, A); cyc();
    rq(0, 2'b10, A); rq(1, 2'b10, A); cyc();
    chk("R9", {resp_ok[0], resp_ok[1]}, 2'b01);
    rq(2, 2'b01, C); rq(3, 2'b01, D); cyc();
    rq(2, 2'b10, C); rq(3, 2'b01, C); cyc();
    chk("R9", {resp_ok[2], resp_valid[3]}, 2'b11);

    rq(2, 2'b01, C); cyc();
    idle(WIN + 1);
    snp_v = 1; snp_a = C; cyc();
    rq(2, 2'b10, C); cyc(); chk("R7", {1'b1, resp_ok[2]}, 2'b10);

    rq(2, 2'b01, C); cyc();
    snp_v = 1; snp_a = C + 7; cyc();
    idle(WIN - 3);
    rq(2, 2'b10, C); cyc(); chk("R8", {1'b1, resp_ok[2]}, 2'b11);
    rq(2, 2'b01, C); cyc();
    snp_v = 1; snp_a = C; cyc();
    idle(WIN - 2);
    rq(2, 2'b10, C); cyc(); chk("R8", {1'b1, resp_ok[2]}, 2'b10);

    rq(3, 2'b01, D); cyc();
    rq(3, 2'b00, D); cyc(); chk("R10", {resp_valid[3], resp_ok[3]}, 2'b10);
    rq(3, 2'b10, D); cyc(); chk("R10", {1'b1, resp_ok[3]}, 2'b11);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      for (int t = 0; t < NT; t++)
        if ($urandom_range(1, 0) == 1)
          rq(t, 2'($urandom_range(3, 0)), (32'h1000 + 32'($urandom_range(3, 0)) * 8) | 32'($urandom_range(7, 0)));
      if ($urandom_range(4, 0) == 0) begin
        snp_v = 1;
        snp_a = (32'h1000 + 32'($urandom_range(3, 0)) * 8) | 32'($urandom_range(7, 0));
      end
      cyc();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule